// File: doc/BRIEF.md
# Receive Packet FIFO with Error Discard

This block buffers one Ethernet port's received frames between the receive MAC and a host read port. The MAC writes one 32-bit word per valid cycle, with flags for first word, last word and error, and a byte count for the last word. A word only becomes readable once its whole packet has been committed by a last-word write. Until then the host does not see it.

A packet marked with an error is removed from storage. Packets committed ahead of it are kept. A sticky discard flag then rises and stays high until the host pulses the clear input. An abort input empties the whole FIFO without raising the discard flag, and a configuration bit can turn the abort input off. After an error, an abort or an overflow, the write side ignores every word up to the next first-of-packet word.

When status appending is on, a status word is stored directly after the last data word of each packet. The status word carries the packet's byte count and an error bit.

Top module: `rx_pkt_fifo`

## Requirements
- R1: `rd_valid_o` is high when at least one committed word is unread. `data_avail_o` is high only when more than one committed word is unread.
- R2: Words of a packet become readable only after its last word (`wr_eop_i`) is accepted. They are then read in write order.
- R3: A word accepted with `wr_err_i` high removes every stored word of its packet and sets `discard_o` on the next cycle. Packets committed earlier stay readable and unchanged.
- R4: While `discard_o` is high, every write is ignored, including words marked as first of packet.
- R5: `discard_o` falls only after a `clr_err_i` pulse. After that, words without `wr_sop_i` are ignored until a first-of-packet word arrives. Words that follow a packet's last word without `wr_sop_i` are also ignored.
- R6: With `cfg_abort_dis_i` low, an `abort_i` pulse empties the FIFO by the next cycle and leaves `discard_o` unchanged. Writes then resume only at a first-of-packet word.
- R7: With `cfg_abort_dis_i` high, `abort_i` has no effect on stored data or on acceptance.
- R8: With `cfg_status_en_i` high, the word after a packet's last data word is a status word. Its bits [15:0] hold the byte count: 4 per word, except the last word, which counts `wr_last_bytes_i` bytes (0 means 4). Bit 16 is the error bit, always 0 for a delivered packet. Bits [31:17] are zero.
- R9: A write that finds too little room (one slot, or two when a status word is due) is dropped and handled like an errored word as in R3. The FIFO never holds more than DEPTH words.
- R10: A host read in the same cycle as an error flush completes normally: the read pointer advances and the next committed word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write word valid |
| wr_data_i | input | 32 | Write word |
| wr_sop_i | input | 1 | Word is first of packet |
| wr_eop_i | input | 1 | Word is last of packet |
| wr_err_i | input | 1 | Packet has a receive error |
| wr_last_bytes_i | input | 2 | Valid bytes in last word, 0 = 4 |
| rd_en_i | input | 1 | Host pops the presented word |
| rd_data_o | output | 32 | Presented word |
| rd_valid_o | output | 1 | At least one committed word unread |
| data_avail_o | output | 1 | More than one committed word unread |
| discard_o | output | 1 | Sticky discard flag |
| clr_err_i | input | 1 | Clears the discard flag |
| abort_i | input | 1 | Empty the FIFO |
| cfg_abort_dis_i | input | 1 | Ignore abort_i when high |
| cfg_status_en_i | input | 1 | Append a status word per packet |

## Verification
The host read port and the error flush both move pointers over the same storage, so they can collide in one cycle. The bench commits a three-word packet and starts a second packet. It then raises `rd_en_i` in the same cycle as the errored word of the second packet. It judges the result by requiring that `discard_o` rises and that the second committed word is presented afterwards. The remaining words of the first packet must then drain intact and the FIFO must end empty.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 16;

  function automatic logic [WORD_W-1:0] make_status(input logic [CNT_W-1:0] bytes,
                                                    input logic err);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CNT_W-1:0] = bytes;
    w[CNT_W]     = err;
    return w;
  endfunction
endpackage

// File: rtl/rx_fifo_mem.sv
module rx_fifo_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we0_i,
  input  logic [AW-1:0] a0_i,
  input  logic [W-1:0]  d0_i,
  input  logic          we1_i,
  input  logic [AW-1:0] a1_i,
  input  logic [W-1:0]  d1_i,
  input  logic [AW-1:0] ra_i,
  output logic [W-1:0]  rd_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we0_i) mem_q[a0_i] <= d0_i;
    if (we1_i) mem_q[a1_i] <= d1_i;
  end

  assign rd_o = mem_q[ra_i];
endmodule

// File: rtl/rx_byte_count.sv
module rx_byte_count
  import rx_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [1:0]       last_bytes_i,
  output logic [CNT_W-1:0] bytes_o
);
  logic [CNT_W-1:0] cnt_q, add;

  always_comb begin
    add = CNT_W'(4);
    if (eop_i && last_bytes_i != 2'd0) add = CNT_W'(last_bytes_i);
  end

  // running total including the current word
  assign bytes_o = (sop_i ? '0 : cnt_q) + add;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (take_i) cnt_q <= bytes_o;
  end
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          wr_sop_i,
  input  logic          wr_eop_i,
  input  logic          wr_err_i,
  input  logic          rd_en_i,
  input  logic          clr_err_i,
  input  logic          abort_i,
  input  logic          cfg_abort_dis_i,
  input  logic          cfg_status_en_i,
  output logic          take_o,
  output logic          we0_o,
  output logic [AW-1:0] a0_o,
  output logic          we1_o,
  output logic [AW-1:0] a1_o,
  output logic [AW-1:0] ra_o,
  output logic          rd_valid_o,
  output logic          data_avail_o,
  output logic          discard_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [PW-1:0] cm_ptr_o
);
  logic [PW-1:0] wr_q, cm_q, rd_q;
  logic          gate_q, disc_q;

  logic          abort_eff, take, ovf, bad, good, rd_go, add_st;
  logic [PW-1:0] base, used, need, nxt, cm_cnt;
  logic [PW:0]   free_w;

  assign abort_eff = abort_i & ~cfg_abort_dis_i;
  assign take      = wr_valid_i & ~disc_q & (~gate_q | wr_sop_i) & ~abort_eff;
  // a new sop restarts from the committed pointer, dropping any unfinished packet
  assign base      = wr_sop_i ? cm_q : wr_q;
  assign add_st    = wr_eop_i & cfg_status_en_i;
  assign need      = add_st ? PW'(2) : PW'(1);
  assign used      = base - rd_q;
  assign free_w    = (PW+1)'(DEPTH) - {1'b0, used};
  assign ovf       = free_w < {1'b0, need};
  assign bad       = take & (wr_err_i | ovf);
  assign good      = take & ~bad;
  assign nxt       = base + need;

  assign cm_cnt       = cm_q - rd_q;
  assign rd_valid_o   = cm_cnt != '0;
  assign data_avail_o = cm_cnt > PW'(1);
  assign rd_go        = rd_en_i & rd_valid_o & ~abort_eff;

  assign take_o = take;
  assign we0_o  = good;
  assign a0_o   = base[AW-1:0];
  assign we1_o  = good & add_st;
  assign a1_o   = AW'(base + PW'(1));
  assign ra_o   = rd_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      cm_q   <= '0;
      rd_q   <= '0;
      gate_q <= 1'b1;
    end else if (abort_eff) begin
      wr_q   <= '0;
      cm_q   <= '0;
      rd_q   <= '0;
      gate_q <= 1'b1;
    end else begin
      if (rd_go) rd_q <= rd_q + PW'(1);
      if (bad) begin
        wr_q   <= cm_q;
        gate_q <= 1'b1;
      end else if (good) begin
        wr_q   <= nxt;
        gate_q <= wr_eop_i;
        if (wr_eop_i) cm_q <= nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        disc_q <= 1'b0;
    else if (bad)       disc_q <= 1'b1;
    else if (clr_err_i) disc_q <= 1'b0;
  end

  assign discard_o = disc_q;
  assign wr_ptr_o  = wr_q;
  assign rd_ptr_o  = rd_q;
  assign cm_ptr_o  = cm_q;
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              wr_sop_i,
  input  logic              wr_eop_i,
  input  logic              wr_err_i,
  input  logic [1:0]        wr_last_bytes_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              data_avail_o,
  output logic              discard_o,
  input  logic              clr_err_i,
  input  logic              abort_i,
  input  logic              cfg_abort_dis_i,
  input  logic              cfg_status_en_i
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic          take, we0, we1;
  logic [AW-1:0] a0, a1, ra;
  logic [PW-1:0] wr_ptr, rd_ptr, cm_ptr;
  logic [CNT_W-1:0] bytes;
  logic [WORD_W-1:0] stat_word;

  rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_valid_i, .wr_sop_i, .wr_eop_i, .wr_err_i, .rd_en_i,
    .clr_err_i, .abort_i, .cfg_abort_dis_i, .cfg_status_en_i,
    .take_o(take), .we0_o(we0), .a0_o(a0), .we1_o(we1), .a1_o(a1), .ra_o(ra),
    .rd_valid_o, .data_avail_o, .discard_o,
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .cm_ptr_o(cm_ptr)
  );

  rx_byte_count u_cnt (
    .clk_i, .rst_ni, .take_i(take), .sop_i(wr_sop_i), .eop_i(wr_eop_i),
    .last_bytes_i(wr_last_bytes_i), .bytes_o(bytes)
  );

  assign stat_word = make_status(bytes, wr_err_i);

  rx_fifo_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
    .clk_i, .we0_i(we0), .a0_i(a0), .d0_i(wr_data_i),
    .we1_i(we1), .a1_i(a1), .d1_i(stat_word), .ra_i(ra), .rd_o(rd_data_o)
  );
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          abort_i,
  input logic          cfg_abort_dis_i,
  input logic          clr_err_i,
  input logic          rd_valid_o,
  input logic          data_avail_o,
  input logic          discard_o,
  input logic [PW-1:0] wr_ptr_i,
  input logic [PW-1:0] rd_ptr_i,
  input logic [PW-1:0] cm_ptr_i
);
  AST_AVAIL_IMPLIES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_avail_o |-> rd_valid_o); // R1

  AST_FLUSH_ON_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(discard_o) |-> wr_ptr_i == cm_ptr_i); // R3

  AST_BLOCK_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o && !(abort_i && !cfg_abort_dis_i) |=> $stable(wr_ptr_i)); // R4

  AST_DISCARD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o && !clr_err_i |=> discard_o); // R5

  AST_CLEAR_ONLY_BY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(discard_o) |-> $past(clr_err_i)); // R5

  AST_ABORT_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && !cfg_abort_dis_i |=> !rd_valid_o); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_i - rd_ptr_i) <= PW'(DEPTH)); // R9
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .abort_i(abort_i), .cfg_abort_dis_i(cfg_abort_dis_i),
  .clr_err_i(clr_err_i), .rd_valid_o(rd_valid_o), .data_avail_o(data_avail_o),
  .discard_o(discard_o), .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr), .cm_ptr_i(cm_ptr)
);

// File: tb/rx_pkt_fifo_tb_top.sv
module rx_pkt_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int NV = 5;
  // [31:24] words, [23:22] last bytes, [21] status en, [20] error, [19:12] words expected, [11:0] byte count
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 2'd1, 1'b0, 1'b0, 8'd1, 12'd1},
    {8'd3, 2'd0, 1'b1, 1'b0, 8'd4, 12'd12},
    {8'd2, 2'd3, 1'b1, 1'b0, 8'd3, 12'd7},
    {8'd4, 2'd2, 1'b1, 1'b1, 8'd0, 12'd0},
    {8'd5, 2'd1, 1'b1, 1'b0, 8'd6, 12'd17}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_sop = 0, wr_eop = 0, wr_err = 0, rd_en = 0;
  logic clr_err = 0, abort = 0, cfg_abort_dis = 0, cfg_sten = 0;
  logic [1:0]  wr_lb = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic rd_valid, data_avail, discard;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_sop_i(wr_sop), .wr_eop_i(wr_eop), .wr_err_i(wr_err), .wr_last_bytes_i(wr_lb),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .data_avail_o(data_avail),
    .discard_o(discard), .clr_err_i(clr_err), .abort_i(abort),
    .cfg_abort_dis_i(cfg_abort_dis), .cfg_status_en_i(cfg_sten)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] d, input logic sop, input logic eop,
                         input logic err, input logic [1:0] lb);
    @(negedge clk);
    wr_valid = 1; wr_data = d; wr_sop = sop; wr_eop = eop; wr_err = err; wr_lb = lb;
    @(negedge clk);
    wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_err = 0;
  endtask

  task automatic rd_word(output logic [31:0] d);
    @(negedge clk);
    d = rd_data; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic clr_pulse();
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0;
  endtask

  task automatic abort_pulse();
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(rd_valid), 0);
    chk("R1 reset avail", 32'(data_avail), 0);
    chk("R5 reset discard", 32'(discard), 0);
    rst_n = 1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      int words, expw;
      v = VEC[i];
      words = int'(v[31:24]);
      expw  = int'(v[19:12]);
      cfg_sten = v[21];
      for (int k = 0; k < words; k++)
        wr_word(32'(i * 256 + k), k == 0, k == words - 1, v[20] && k == words - 1, v[23:22]);
      chk("R1 avail after packet", 32'(data_avail), 32'(expw > 1));
      chk("R2 valid after packet", 32'(rd_valid), 32'(expw != 0));
      if (v[20]) begin
        chk("R3 discard set", 32'(discard), 1);
        clr_pulse();
        chk("R5 discard cleared", 32'(discard), 0);
      end
      for (int k = 0; k < expw; k++) begin
        rd_word(d);
        if (v[21] && k == expw - 1) chk("R8 status word", d, 32'(v[11:0]));
        else chk("R2 data order", d, 32'(i * 256 + k));
      end
      chk("R1 drained", 32'(rd_valid), 0);
    end

    // R2: nothing visible before eop
    cfg_sten = 0;
    wr_word(32'h100, 1, 0, 0, 0);
    wr_word(32'h101, 0, 0, 0, 0);
    chk("R2 hidden before eop", 32'(rd_valid), 0);
    wr_word(32'h102, 0, 1, 0, 0);
    chk("R1 avail 3 words", 32'(data_avail), 1);
    for (int k = 0; k < 3; k++) begin rd_word(d); chk("R2 data", d, 32'h100 + 32'(k)); end

    // R3/R4/R5: error keeps committed packet, blocks writes, needs clear and sop
    wr_word(32'hA0, 1, 0, 0, 0);
    wr_word(32'hA1, 0, 1, 0, 0);
    wr_word(32'hB0, 1, 0, 0, 0);
    wr_word(32'hB1, 0, 0, 1, 0);
    chk("R3 discard on error", 32'(discard), 1);
    wr_word(32'hB2, 1, 1, 0, 0);
    chk("R4 still blocked", 32'(discard), 1);
    clr_pulse();
    wr_word(32'hC0, 0, 1, 0, 0);
    wr_word(32'hD0, 1, 1, 0, 0);
    rd_word(d); chk("R3 earlier packet kept", d, 32'hA0);
    rd_word(d); chk("R3 earlier packet kept", d, 32'hA1);
    rd_word(d); chk("R5 resume at sop only", d, 32'hD0);
    chk("R4 blocked words absent", 32'(rd_valid), 0);

    // R5: word after eop without sop ignored
    wr_word(32'hE5, 1, 1, 0, 0);
    wr_word(32'hE6, 0, 1, 0, 0);
    rd_word(d); chk("R5 packet", d, 32'hE5);
    chk("R5 non-sop after eop ignored", 32'(rd_valid), 0);

    // R10: read in the same cycle as error flush
    wr_word(32'hE0, 1, 0, 0, 0);
    wr_word(32'hE1, 0, 0, 0, 0);
    wr_word(32'hE2, 0, 1, 0, 0);
    wr_word(32'hF0, 1, 0, 0, 0);
    @(negedge clk);
    chk("R10 head before", rd_data, 32'hE0);
    rd_en = 1; wr_valid = 1; wr_data = 32'hF1; wr_err = 1;
    @(negedge clk);
    rd_en = 0; wr_valid = 0; wr_err = 0;
    chk("R10 discard raised", 32'(discard), 1);
    chk("R10 read advanced", rd_data, 32'hE1);
    rd_word(d); chk("R10 drain", d, 32'hE1);
    rd_word(d); chk("R10 drain", d, 32'hE2);
    chk("R10 flushed packet absent", 32'(rd_valid), 0);
    clr_pulse();

    // R6: abort
    wr_word(32'h60, 1, 0, 0, 0);
    wr_word(32'h61, 0, 1, 0, 0);
    abort_pulse();
    chk("R6 emptied", 32'(rd_valid), 0);
    chk("R6 no discard", 32'(discard), 0);
    wr_word(32'h62, 0, 1, 0, 0);
    chk("R6 non-sop ignored", 32'(rd_valid), 0);
    wr_word(32'h77, 1, 1, 0, 0);
    rd_word(d); chk("R6 resume at sop", d, 32'h77);

    // R7: abort disabled
    cfg_abort_dis = 1;
    wr_word(32'h55, 1, 1, 0, 0);
    abort_pulse();
    chk("R7 abort ignored", 32'(rd_valid), 1);
    rd_word(d); chk("R7 data intact", d, 32'h55);
    cfg_abort_dis = 0;

    // R9: overflow
    for (int k = 0; k < DEPTH; k++) wr_word(32'h200 + 32'(k), k == 0, 0, 0, 0);
    chk("R9 full no discard yet", 32'(discard), 0);
    wr_word(32'h2FF, 0, 1, 0, 0);
    chk("R9 overflow discard", 32'(discard), 1);
    chk("R9 nothing committed", 32'(rd_valid), 0);
    clr_pulse();
    wr_word(32'h99, 1, 1, 0, 0);
    rd_word(d); chk("R9 recovers", d, 32'h99);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule